// File: doc/BRIEF.md
# Codec Mode Register and Decoder

This block keeps the single 8-bit configuration byte of a telephony voice codec. A serial-instruction front end writes a byte into it with a one-cycle strobe once a transfer completes, and can read the stored byte back at any time. The byte is decoded continuously into mode signals for the rest of the codec: master-clock divider choice, companding law, PCM data timing, loopback mode and power-amplifier behaviour during powerdown.

The block also steers two sample paths inside the digital model. In digital loopback the received PCM word replaces the encoder output as the source of the transmit PCM register. In analog loopback the receive-side output sample replaces the external transmit input sample, which closes the loop from the receive PCM register back to the transmit PCM register through the converters. Gains are not touched by either mode.

Top module: `codec_mode_ctrl`

## Requirements
- R1: A synchronous active-high reset loads the byte 8'h89, which decodes to the 2.048 MHz clock choice, mu-255 law, non-delayed timing, normal operation and amplifier off in powerdown; reset wins over a write in the same cycle.
- R2: A write strobe at a clock edge outside reset stores the byte, and `rd_byte` shows it from that edge onward.
- R3: Without a write strobe or reset the stored byte and every decoded output hold their values.
- R4: `clk_sel_code` equals bits 7:6 of the byte (00 = 512 kHz, 01 = 1.536/1.544 MHz, 10 = 2.048 MHz, 11 = 4.096 MHz) and `clk_sel_hot` has exactly bit `clk_sel_code` set.
- R5: `law_hot` is one-hot: bit 0 (mu-255) when byte bit 5 is 0 whatever bit 4 holds, bit 1 (A-law with even-bit inversion) when bits 5:4 are 10, bit 2 (A-law without inversion) when bits 5:4 are 11.
- R6: `delayed_timing` is 1 exactly when byte bit 3 is 0.
- R7: With byte bits 2:1 read as (bit 2, bit 1): 10 gives `loop_dig`, 11 gives `loop_ana`, and 00 and the undefined 01 give neither; the two are never high together.
- R8: `pa_off_pdn` equals byte bit 0 (1 = amplifier disabled in powerdown).
- R9: `tx_pcm_out` equals `rx_pcm_in` while `loop_dig` is high and `enc_pcm_in` otherwise, in the same cycle.
- R10: `tx_sample_out` equals `rx_sample_in` while `loop_ana` is high and `ext_sample_in` otherwise, in the same cycle.
- R11: Readback returns the stored byte unchanged, including bit 4 when bit 5 is 0 and the undefined loopback code 01.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | One-cycle write strobe at end of a byte transfer |
| wr_byte | input | 8 | Byte to store |
| rd_byte | output | 8 | Stored byte for readback |
| clk_sel_code | output | 2 | Encoded master-clock divider choice |
| clk_sel_hot | output | 4 | One-hot master-clock divider choice |
| law_hot | output | 3 | One-hot companding law (mu, A inverted, A plain) |
| delayed_timing | output | 1 | 1 = delayed PCM data timing |
| loop_dig | output | 1 | Digital loopback active |
| loop_ana | output | 1 | Analog loopback active |
| pa_off_pdn | output | 1 | 1 = power amplifier disabled in powerdown |
| enc_pcm_in | input | PCM_W | Encoder output PCM word |
| rx_pcm_in | input | PCM_W | Received PCM word |
| tx_pcm_out | output | PCM_W | Word fed to the transmit PCM register |
| ext_sample_in | input | SAMPLE_W | External transmit input sample |
| rx_sample_in | input | SAMPLE_W | Receive-side output sample |
| tx_sample_out | output | SAMPLE_W | Sample fed to the transmit input path |

## Verification
Every byte value from 0 to 255 is written, so the law field with its don't-care bit, the undefined loopback code 01 and all four clock choices are covered; a decoder that treated 01 as analog loopback or let bit 4 change the mu-law choice would show a wrong strobe in that cycle. Idle cycles between writes, with fresh random samples, expose a register that drifts or a path mux that latches old data. A reset asserted together with a write catches a design that lets the write win, and readback of bytes with don't-care bits set catches one that normalises the stored value.

// File: rtl/codec_mode_pkg.sv
package codec_mode_pkg;

    localparam int MODE_W = 8;
    localparam logic [MODE_W-1:0] MODE_RESET = 8'h89;

    // field positions (downstream decoding depends on them)
    localparam int CLK_HI   = 7;
    localparam int CLK_LO   = 6;
    localparam int LAW_SEL  = 5;
    localparam int LAW_PLN  = 4;
    localparam int TIM_BIT  = 3;
    localparam int LOOP_EN  = 2;
    localparam int LOOP_ANA = 1;
    localparam int PA_BIT   = 0;

    localparam int CLK_CNT = 4;
    localparam int LAW_CNT = 3;

    typedef enum logic [1:0] {
        CLK_512K  = 2'b00,
        CLK_1M5   = 2'b01,
        CLK_2M048 = 2'b10,
        CLK_4M096 = 2'b11
    } clk_sel_e;

    typedef enum logic [1:0] {
        LAW_MU      = 2'd0,
        LAW_A_INV   = 2'd1,
        LAW_A_PLAIN = 2'd2
    } law_e;

    typedef enum logic [1:0] {
        LOOP_OFF     = 2'd0,
        LOOP_DIGITAL = 2'd1,
        LOOP_ANALOG  = 2'd2
    } loop_e;

    typedef struct packed {
        clk_sel_e clk;
        law_e     law;
        logic     delayed;
        loop_e    loop;
        logic     pa_off;
    } mode_t;

    function automatic law_e decode_law(input logic sel, input logic plain);
        if (!sel)
            return LAW_MU;
        else if (!plain)
            return LAW_A_INV;
        else
            return LAW_A_PLAIN;
    endfunction

    function automatic loop_e decode_loop(input logic en, input logic ana);
        case ({en, ana})
            2'b10:   return LOOP_DIGITAL;
            2'b11:   return LOOP_ANALOG;
            default: return LOOP_OFF;   // 01 undefined -> normal
        endcase
    endfunction

    function automatic mode_t decode_mode(input logic [MODE_W-1:0] b);
        mode_t m;
        m.clk     = clk_sel_e'(b[CLK_HI:CLK_LO]);
        m.law     = decode_law(b[LAW_SEL], b[LAW_PLN]);
        m.delayed = ~b[TIM_BIT];
        m.loop    = decode_loop(b[LOOP_EN], b[LOOP_ANA]);
        m.pa_off  = b[PA_BIT];
        return m;
    endfunction

endpackage

// File: rtl/codec_mode_store.sv
module codec_mode_store
    import codec_mode_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [MODE_W-1:0] wr_byte,
    output logic [MODE_W-1:0] mode_byte
);

    always_ff @(posedge clk) begin
        if (rst)
            mode_byte <= MODE_RESET;
        else if (wr_en)
            mode_byte <= wr_byte;
    end

endmodule

// File: rtl/codec_mode_decode.sv
module codec_mode_decode
    import codec_mode_pkg::*;
(
    input  logic [MODE_W-1:0]  mode_byte,
    output logic [1:0]         clk_sel_code,
    output logic [CLK_CNT-1:0] clk_sel_hot,
    output logic [LAW_CNT-1:0] law_hot,
    output logic               delayed_timing,
    output logic               loop_dig,
    output logic               loop_ana,
    output logic               pa_off_pdn
);

    mode_t mode;

    always_comb mode = decode_mode(mode_byte);

    assign clk_sel_code = mode.clk;

    for (genvar c = 0; c < CLK_CNT; c++) begin : g_clk_hot
        assign clk_sel_hot[c] = (mode.clk == clk_sel_e'(c));
    end

    for (genvar l = 0; l < LAW_CNT; l++) begin : g_law_hot
        assign law_hot[l] = (mode.law == law_e'(l));
    end

    assign delayed_timing = mode.delayed;
    assign loop_dig       = (mode.loop == LOOP_DIGITAL);
    assign loop_ana       = (mode.loop == LOOP_ANALOG);
    assign pa_off_pdn     = mode.pa_off;

endmodule

// File: rtl/codec_loop_steer.sv
module codec_loop_steer #(
    parameter int PCM_W    = 8,
    parameter int SAMPLE_W = 14
) (
    input  logic                loop_dig,
    input  logic                loop_ana,
    input  logic [PCM_W-1:0]    enc_pcm_in,
    input  logic [PCM_W-1:0]    rx_pcm_in,
    output logic [PCM_W-1:0]    tx_pcm_out,
    input  logic [SAMPLE_W-1:0] ext_sample_in,
    input  logic [SAMPLE_W-1:0] rx_sample_in,
    output logic [SAMPLE_W-1:0] tx_sample_out
);

    // digital loopback: received word goes straight to transmit register
    always_comb begin
        if (loop_dig)
            tx_pcm_out = rx_pcm_in;
        else
            tx_pcm_out = enc_pcm_in;
    end

    // analog loopback: receive output sample replaces the external input
    always_comb begin
        if (loop_ana)
            tx_sample_out = rx_sample_in;
        else
            tx_sample_out = ext_sample_in;
    end

endmodule

// File: rtl/codec_mode_ctrl.sv
module codec_mode_ctrl
    import codec_mode_pkg::*;
#(
    parameter int PCM_W    = 8,
    parameter int SAMPLE_W = 14
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [7:0]          wr_byte,
    output logic [7:0]          rd_byte,
    output logic [1:0]          clk_sel_code,
    output logic [3:0]          clk_sel_hot,
    output logic [2:0]          law_hot,
    output logic                delayed_timing,
    output logic                loop_dig,
    output logic                loop_ana,
    output logic                pa_off_pdn,
    input  logic [PCM_W-1:0]    enc_pcm_in,
    input  logic [PCM_W-1:0]    rx_pcm_in,
    output logic [PCM_W-1:0]    tx_pcm_out,
    input  logic [SAMPLE_W-1:0] ext_sample_in,
    input  logic [SAMPLE_W-1:0] rx_sample_in,
    output logic [SAMPLE_W-1:0] tx_sample_out
);

    logic [MODE_W-1:0] mode_byte;

    codec_mode_store u_store (
        .clk       (clk),
        .rst       (rst),
        .wr_en     (wr_en),
        .wr_byte   (wr_byte),
        .mode_byte (mode_byte)
    );

    assign rd_byte = mode_byte;

    codec_mode_decode u_decode (
        .mode_byte      (mode_byte),
        .clk_sel_code   (clk_sel_code),
        .clk_sel_hot    (clk_sel_hot),
        .law_hot        (law_hot),
        .delayed_timing (delayed_timing),
        .loop_dig       (loop_dig),
        .loop_ana       (loop_ana),
        .pa_off_pdn     (pa_off_pdn)
    );

    codec_loop_steer #(
        .PCM_W    (PCM_W),
        .SAMPLE_W (SAMPLE_W)
    ) u_steer (
        .loop_dig      (loop_dig),
        .loop_ana      (loop_ana),
        .enc_pcm_in    (enc_pcm_in),
        .rx_pcm_in     (rx_pcm_in),
        .tx_pcm_out    (tx_pcm_out),
        .ext_sample_in (ext_sample_in),
        .rx_sample_in  (rx_sample_in),
        .tx_sample_out (tx_sample_out)
    );

endmodule

// File: rtl/codec_mode_ctrl_chk.sv
module codec_mode_ctrl_chk #(
    parameter int PCM_W    = 8,
    parameter int SAMPLE_W = 14
) (
    input logic                clk,
    input logic                rst,
    input logic                wr_en,
    input logic [7:0]          wr_byte,
    input logic [7:0]          rd_byte,
    input logic [1:0]          clk_sel_code,
    input logic [3:0]          clk_sel_hot,
    input logic [2:0]          law_hot,
    input logic                delayed_timing,
    input logic                loop_dig,
    input logic                loop_ana,
    input logic                pa_off_pdn,
    input logic [PCM_W-1:0]    enc_pcm_in,
    input logic [PCM_W-1:0]    rx_pcm_in,
    input logic [PCM_W-1:0]    tx_pcm_out,
    input logic [SAMPLE_W-1:0] ext_sample_in,
    input logic [SAMPLE_W-1:0] rx_sample_in,
    input logic [SAMPLE_W-1:0] tx_sample_out
);

    assert_write_lands_R2: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> rd_byte == $past(wr_byte));

    assert_hold_idle_R3: assert property (@(posedge clk) disable iff (rst)
        !wr_en |=> $stable(rd_byte) && $stable(law_hot) && $stable(clk_sel_hot));

    assert_clk_hot_R4: assert property (@(posedge clk) disable iff (rst)
        $countones(clk_sel_hot) == 1 && clk_sel_hot[clk_sel_code]
        && clk_sel_code == rd_byte[7:6]);

    assert_law_onehot_R5: assert property (@(posedge clk) disable iff (rst)
        $countones(law_hot) == 1 && (law_hot[0] == !rd_byte[5]));

    assert_timing_R6: assert property (@(posedge clk) disable iff (rst)
        delayed_timing != rd_byte[3]);

    assert_loop_excl_R7: assert property (@(posedge clk) disable iff (rst)
        $onehot0({loop_dig, loop_ana}) && (loop_ana == (rd_byte[2:1] == 2'b11)));

    assert_pa_bit_R8: assert property (@(posedge clk) disable iff (rst)
        pa_off_pdn == rd_byte[0]);

    assert_dig_path_R9: assert property (@(posedge clk) disable iff (rst)
        tx_pcm_out == (loop_dig ? rx_pcm_in : enc_pcm_in));

    assert_ana_path_R10: assert property (@(posedge clk) disable iff (rst)
        tx_sample_out == (loop_ana ? rx_sample_in : ext_sample_in));

endmodule

bind codec_mode_ctrl codec_mode_ctrl_chk #(
    .PCM_W    (PCM_W),
    .SAMPLE_W (SAMPLE_W)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .wr_en          (wr_en),
    .wr_byte        (wr_byte),
    .rd_byte        (rd_byte),
    .clk_sel_code   (clk_sel_code),
    .clk_sel_hot    (clk_sel_hot),
    .law_hot        (law_hot),
    .delayed_timing (delayed_timing),
    .loop_dig       (loop_dig),
    .loop_ana       (loop_ana),
    .pa_off_pdn     (pa_off_pdn),
    .enc_pcm_in     (enc_pcm_in),
    .rx_pcm_in      (rx_pcm_in),
    .tx_pcm_out     (tx_pcm_out),
    .ext_sample_in  (ext_sample_in),
    .rx_sample_in   (rx_sample_in),
    .tx_sample_out  (tx_sample_out)
);

// File: tb/codec_mode_ctrl_test.sv
module codec_mode_ctrl_test;

    localparam int PCM_W    = 8;
    localparam int SAMPLE_W = 14;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                wr_en = 1'b0;
    logic [7:0]          wr_byte = '0;
    logic [7:0]          rd_byte;
    logic [1:0]          clk_sel_code;
    logic [3:0]          clk_sel_hot;
    logic [2:0]          law_hot;
    logic                delayed_timing, loop_dig, loop_ana, pa_off_pdn;
    logic [PCM_W-1:0]    enc_pcm_in = '0, rx_pcm_in = '0, tx_pcm_out;
    logic [SAMPLE_W-1:0] ext_sample_in = '0, rx_sample_in = '0, tx_sample_out;

    int errors = 0;
    int checks = 0;
    logic [7:0] model_byte = 8'h89;

    always #10 clk = ~clk;   // 50 MHz

    codec_mode_ctrl #(.PCM_W(PCM_W), .SAMPLE_W(SAMPLE_W)) uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_byte(wr_byte), .rd_byte(rd_byte),
        .clk_sel_code(clk_sel_code), .clk_sel_hot(clk_sel_hot), .law_hot(law_hot),
        .delayed_timing(delayed_timing), .loop_dig(loop_dig), .loop_ana(loop_ana),
        .pa_off_pdn(pa_off_pdn), .enc_pcm_in(enc_pcm_in), .rx_pcm_in(rx_pcm_in),
        .tx_pcm_out(tx_pcm_out), .ext_sample_in(ext_sample_in),
        .rx_sample_in(rx_sample_in), .tx_sample_out(tx_sample_out)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // behavioural expectation from the requirement text
    task automatic compare_all();
        logic [2:0] e_law;
        logic e_dig, e_ana;
        if (model_byte[5] == 1'b0)      e_law = 3'b001;
        else if (model_byte[4] == 1'b0) e_law = 3'b010;
        else                            e_law = 3'b100;
        e_dig = (model_byte[2:1] == 2'b10);
        e_ana = (model_byte[2:1] == 2'b11);
        check("R2/R3/R11", "rd_byte", 32'(rd_byte), 32'(model_byte));
        check("R4", "clk_sel_code", 32'(clk_sel_code), 32'(model_byte[7:6]));
        check("R4", "clk_sel_hot", 32'(clk_sel_hot), 32'(4'b0001 << model_byte[7:6]));
        check("R5", "law_hot", 32'(law_hot), 32'(e_law));
        check("R6", "delayed_timing", 32'(delayed_timing), 32'(model_byte[3] ? 1 : 0) ^ 32'd1);
        check("R7", "loop_dig", 32'(loop_dig), 32'(e_dig));
        check("R7", "loop_ana", 32'(loop_ana), 32'(e_ana));
        check("R8", "pa_off_pdn", 32'(pa_off_pdn), 32'(model_byte[0]));
        check("R9", "tx_pcm_out", 32'(tx_pcm_out), 32'(e_dig ? rx_pcm_in : enc_pcm_in));
        check("R10", "tx_sample_out", 32'(tx_sample_out),
              32'(e_ana ? rx_sample_in : ext_sample_in));
    endtask

    // called at a negedge: drive, let the edge happen, update model, compare
    task automatic step(input logic r, input logic w, input logic [7:0] d);
        rst = r; wr_en = w; wr_byte = d;
        enc_pcm_in    = PCM_W'($urandom);
        rx_pcm_in     = PCM_W'($urandom);
        ext_sample_in = SAMPLE_W'($urandom);
        rx_sample_in  = SAMPLE_W'($urandom);
        @(posedge clk);
        if (r)      model_byte = 8'h89;
        else if (w) model_byte = d;
        @(negedge clk);
        compare_all();
    endtask

    initial begin
        @(negedge clk);
        step(1'b1, 1'b0, 8'h00);
        step(1'b1, 1'b0, 8'h00);
        // R1: reset defaults at the ports
        check("R1", "reset byte", 32'(rd_byte), 32'h89);
        check("R1", "reset clock 2.048", 32'(clk_sel_hot), 32'b0100);
        check("R1", "reset mu law", 32'(law_hot), 32'b001);
        check("R1", "reset timing non-delayed", 32'(delayed_timing), 32'd0);
        check("R1", "reset normal loop", 32'({loop_dig, loop_ana}), 32'd0);
        check("R1", "reset pa off", 32'(pa_off_pdn), 32'd1);

        // sweep every byte, each followed by an idle cycle (R3)
        for (int b = 0; b < 256; b++) begin
            step(1'b0, 1'b1, 8'(b));
            step(1'b0, 1'b0, 8'(~b));
        end

        // R7: undefined loop code 01 is normal; R11: it reads back as written
        step(1'b0, 1'b1, 8'h12);
        check("R7", "code 01 no analog", 32'(loop_ana), 32'd0);
        check("R11", "code 01 readback", 32'(rd_byte), 32'h12);
        // R5 / R11: bit 4 don't-care under mu law kept in readback
        step(1'b0, 1'b1, 8'h1C);
        check("R5", "mu with bit4 set", 32'(law_hot), 32'b001);
        check("R11", "bit4 kept", 32'(rd_byte), 32'h1C);
        // R9 / R10: loops back to back
        step(1'b0, 1'b1, 8'h04);
        check("R9", "digital path", 32'(tx_pcm_out), 32'(rx_pcm_in));
        step(1'b0, 1'b1, 8'h06);
        check("R10", "analog path", 32'(tx_sample_out), 32'(rx_sample_in));
        check("R9", "analog keeps encoder", 32'(tx_pcm_out), 32'(enc_pcm_in));
        // R1: reset beats a concurrent write
        step(1'b1, 1'b1, 8'h00);
        check("R1", "reset over write", 32'(rd_byte), 32'h89);
        step(1'b0, 1'b0, 8'hFF);
        step(1'b0, 1'b0, 8'hFF);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule